// File: doc/BRIEF.md
# MDIO Management Frame Master

This block sits on the MAC side of a management link and runs one register access at a time toward a PHY. It generates the management clock from the system clock and shifts a complete serial frame onto the bidirectional data line. A frame starts with a run of ones for synchronisation. Then come fixed start and operation codes, the PHY and register addresses, a two-bit turnaround and a 16-bit data field. The data line is presented as three signals: an output value, an output enable and an input. The pad or the bench combines them into the tristate wire.

A host pulses `start` and supplies the direction, both addresses, the write data and a clock divide setting. The block returns a single-cycle `done`. On a read, the captured data and an error flag for a bad turnaround accompany `done`. The divide setting is clamped to a floor derived from the system clock period. Because of this, the management clock can never run faster than 2.5 MHz, and its high and low phases can never be shorter than 200 ns.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction is in progress, `mdio_oe` is 0, `mdc` is 0 and `done` is 0.
- R2: Frame positions 0 to 31 (position p is the bit present at the p-th rising edge of `mdc`, counted from 0) are all logic 1.
- R3: Positions 32 and 33 carry 0 then 1. Positions 34 and 35 carry 1,0 for a read (`rd_nwr`=1) and 0,1 for a write (`rd_nwr`=0).
- R4: Positions 36 to 40 carry `phy_addr` and positions 41 to 45 carry `reg_addr`, each most significant bit first.
- R5: On a write, positions 46 and 47 carry 1 then 0, positions 48 to 63 carry `wr_data` MSB first, and `mdio_oe` stays 1 for the whole frame.
- R6: On a read, `mdio_oe` is 0 from position 46 to the end of the frame. The line values sampled at the rising edges of positions 48 to 63 appear on `rd_data`, MSB first, while `done` is high. `rd_data` keeps this value until the next read completes.
- R7: On a read, `rd_err` is 1 together with `done` exactly when the line sampled at position 47 is not 0. `rd_err` is 0 after a write and at all times when `done` is 0.
- R8: Each `mdc` high phase and low phase lasts H system clocks, where H = max(`div_half`, ceil(200 / CLK_PERIOD_NS)), with `div_half` sampled at the accepted start. `mdio_o` and `mdio_oe` change only at edges where `mdc` falls or stays low.
- R9: A `start` pulse while a transaction is in progress is ignored. The running frame is unchanged and exactly one `done` follows it.
- R10: `done` is high for exactly one system clock, beginning at the clock edge where `mdc` falls after position 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| rd_nwr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| div_half | input | DIV_W | Requested MDC half period in system clocks (clamped to floor) |
| rd_data | output | 16 | Data captured by the last read |
| rd_err | output | 1 | Turnaround error flag, valid with done |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Sampled level of the data line |

## Verification
Writes and reads are run with directed extremes: addresses of all zeros and all ones, data of 0x0000, 0xFFFF and alternating patterns, and divide settings below, at and well above the floor. Random addresses, data, directions and divide values are mixed in. Comparing the whole 64-bit line capture against an independently built frame shows field order, opcode choice and bit order together. Measuring every MDC phase shows whether the clamp and the divide setting are honoured. A bench PHY that returns a 1 in the second turnaround bit separates a correct error flag from one that is stuck, or that fires on writes. A start pulse injected mid-frame with different arguments shows whether requests are ignored while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int POS_TA     = 46;
    localparam int POS_DATA   = 48;
    localparam int MIN_PHASE_NS = 200;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t q);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dat;
        op  = q.rd ? OP_READ : OP_WRITE;
        ta  = q.rd ? 2'b00 : TA_WRITE;
        dat = q.rd ? 16'h0000 : q.wdata;
        return {32'hFFFF_FFFF, SOF_CODE, op, q.phy, q.regn, ta, dat};
    endfunction

    function automatic int min_half(int clk_ns);
        int h;
        h = (MIN_PHASE_NS + clk_ns - 1) / clk_ns;
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             mdc,
    output logic             rise_stb,
    output logic             end_stb
);
    localparam int DIV_MAX = (1 << DIV_W) - 1;
    localparam int HMAX    = (MIN_HALF > DIV_MAX) ? MIN_HALF : DIV_MAX;
    localparam int CNT_W   = $clog2(2 * HMAX + 1) + 1;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_HALF);

    logic [CNT_W-1:0] cnt_q, half_q, eff_half, half_m1, period_m1;
    logic             mdc_q;

    assign eff_half  = (CNT_W'(div_half) < MIN_C) ? MIN_C : CNT_W'(div_half);
    assign half_m1   = half_q - 1'b1;
    assign period_m1 = (half_q << 1) - 1'b1;
    assign rise_stb  = run && (cnt_q == half_m1);
    assign end_stb   = run && (cnt_q == period_m1);
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= MIN_C;
            mdc_q  <= 1'b0;
        end else if (load) begin
            cnt_q  <= '0;
            half_q <= eff_half;
            mdc_q  <= 1'b0;
        end else if (run) begin
            if (end_stb) begin
                cnt_q <= '0;
                mdc_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (rise_stb) mdc_q <= 1'b1;
            end
        end else begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_req_t   req,
    input  logic        rise_stb,
    input  logic        end_stb,
    input  logic        mdio_i,
    output logic        load,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic        done
);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] POS_TA2   = POS_W'(POS_TA + 1);
    localparam logic [POS_W-1:0] POS_REL   = POS_W'(POS_TA);
    localparam logic [POS_W-1:0] POS_DAT   = POS_W'(POS_DATA);

    logic                  busy_q, rd_q, ta_bad_q;
    logic [POS_W-1:0]      pos_q, pos_nx;
    logic [FRAME_BITS-1:0] sh_q, frame_w;
    logic [15:0]           cap_q, rdd_q;
    logic                  o_q, oe_q, done_q, err_q;

    assign load    = start && !busy_q;
    assign frame_w = build_frame(req);
    assign pos_nx  = pos_q + 1'b1;
    assign busy    = busy_q;
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;
    assign rd_data = rdd_q;
    assign rd_err  = err_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            rd_q     <= 1'b0;
            ta_bad_q <= 1'b0;
            pos_q    <= '0;
            sh_q     <= '0;
            cap_q    <= '0;
            rdd_q    <= '0;
            o_q      <= 1'b0;
            oe_q     <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (load) begin
                busy_q   <= 1'b1;
                rd_q     <= req.rd;
                ta_bad_q <= 1'b0;
                pos_q    <= '0;
                sh_q     <= frame_w;
                o_q      <= frame_w[FRAME_BITS-1];
                oe_q     <= 1'b1;
            end else if (busy_q) begin
                if (rise_stb && rd_q) begin
                    if (pos_q == POS_TA2) ta_bad_q <= mdio_i;
                    if (pos_q >= POS_DAT) cap_q <= {cap_q[14:0], mdio_i};
                end
                if (end_stb) begin
                    if (pos_q == POS_LAST) begin
                        busy_q <= 1'b0;
                        oe_q   <= 1'b0;
                        o_q    <= 1'b0;
                        done_q <= 1'b1;
                        err_q  <= rd_q && ta_bad_q;
                        if (rd_q) rdd_q <= cap_q;
                    end else begin
                        pos_q <= pos_nx;
                        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                        o_q   <= sh_q[FRAME_BITS-2];
                        oe_q  <= !(rd_q && (pos_nx >= POS_REL));
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int DIV_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_nwr,
    input  logic [4:0]       phy_addr,
    input  logic [4:0]       reg_addr,
    input  logic [15:0]      wr_data,
    input  logic [DIV_W-1:0] div_half,
    output logic [15:0]      rd_data,
    output logic             rd_err,
    output logic             done,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int MIN_HALF = min_half(CLK_PERIOD_NS);

    mdio_req_t req;
    logic      load, busy, rise_stb, end_stb;

    assign req = '{rd: rd_nwr, phy: phy_addr, regn: reg_addr, wdata: wr_data};

    mdio_mdc_gen #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .run      (busy),
        .div_half (div_half),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .end_stb  (end_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .rise_stb (rise_stb),
        .end_stb  (end_stb),
        .mdio_i   (mdio_i),
        .load     (load),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .done     (done)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic rd_err,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdio_oe && !mdc)); // R1

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> done); // R7

    AST_LINE_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> !mdc); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .rd_err  (rd_err),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int CLK_NS = 50;
    localparam int DIV_W  = 8;
    localparam int FLOOR  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             rd_nwr = 1'b0;
    logic [4:0]       phy_addr = '0;
    logic [4:0]       reg_addr = '0;
    logic [15:0]      wr_data = '0;
    logic [DIV_W-1:0] div_half = '0;
    logic [15:0]      rd_data;
    logic             rd_err, done, mdc, mdio_o, mdio_oe;
    logic             phy_oe = 1'b0, phy_o = 1'b0;
    wire              line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    int checks = 0, errors = 0;
    int cyc = 0, rise_cnt = 0, last_rise = 0, last_fall = 0;
    int exp_h = FLOOR;
    bit tim_bad = 1'b0, finished = 1'b0;
    logic [63:0] mon = '0;
    logic        m_rd = 1'b0, m_ta = 1'b0;
    logic [15:0] m_dat = '0;

    mdio_master #(.CLK_PERIOD_NS(CLK_NS), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .div_half(div_half), .rd_data(rd_data), .rd_err(rd_err),
        .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(line)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // bench PHY and line monitor
    always @(posedge mdc) begin
        int n;
        n = rise_cnt;
        mon = {mon[62:0], line};
        if (n > 0 && (cyc - last_rise) != 2 * exp_h) tim_bad = 1'b1;
        last_rise = cyc;
        rise_cnt = n + 1;
        #1;
        if (m_rd) begin
            if (n == 46) begin phy_oe = 1'b1; phy_o = m_ta; end
            else if (n >= 47 && n <= 62) phy_o = m_dat[62-n];
            else if (n == 63) phy_oe = 1'b0;
        end
    end

    always @(negedge mdc) begin
        if ((cyc - last_rise) != exp_h) tim_bad = 1'b1;
        last_fall = cyc;
    end

    function automatic logic [63:0] want_frame(logic rd, logic [4:0] p, logic [4:0] r,
                                               logic [15:0] d, logic ta);
        if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 1'b1, ta, d};
        return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic int want_half(logic [DIV_W-1:0] d);
        return (int'(d) < FLOOR) ? FLOOR : int'(d);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d,
                           logic [DIV_W-1:0] dv, logic ta, bit intrude);
        int dones, wait_n, done_cyc;
        logic [15:0] got_d;
        logic got_e;
        logic [63:0] ef;
        m_rd = rd; m_ta = ta; m_dat = d;
        exp_h = want_half(dv);
        rise_cnt = 0; tim_bad = 1'b0;
        dones = 0; got_d = '0; got_e = 1'b0; done_cyc = 0;
        @(negedge clk);
        rd_nwr = rd; phy_addr = p; reg_addr = r; wr_data = d; div_half = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        if (intrude) begin
            repeat (30 * exp_h) @(negedge clk);
            rd_nwr = ~rd; phy_addr = ~p; reg_addr = ~r; wr_data = ~d; div_half = 8'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (dones == 0 && wait_n < 40000) begin
            @(negedge clk);
            wait_n++;
            if (done) begin
                dones++; got_d = rd_data; got_e = rd_err; done_cyc = cyc;
            end else if (rd_err) begin
                check(1'b0, "R7", "rd_err without done", 1, 0);
            end
        end
        check(dones == 1, "R10", "done seen", dones, 1);
        check(done_cyc == last_fall, "R10", "done at final mdc fall", done_cyc, last_fall);
        repeat (4 * exp_h) begin
            @(negedge clk);
            if (done) dones++;
        end
        check(dones == 1, "R9", "single done per accepted start", dones, 1);
        check(!mdio_oe && !mdc, "R1", "idle after frame oe/mdc", {mdio_oe, mdc}, 0);
        check(rise_cnt == 64, "R8", "mdc rising edges per frame", rise_cnt, 64);
        check(!tim_bad, "R8", "mdc phase length", exp_h, exp_h);
        ef = want_frame(rd, p, r, d, ta);
        check(mon[63:32] == 32'hFFFF_FFFF, "R2", "preamble", mon[63:32], 32'hFFFF_FFFF);
        check(mon[31:28] == ef[31:28], "R3", "start+opcode", mon[31:28], ef[31:28]);
        check(mon[27:18] == ef[27:18], "R4", "addresses", mon[27:18], ef[27:18]);
        if (rd) begin
            check(mon[17] == 1'b1, "R6", "line released at turnaround", mon[17], 1);
            check(got_d == d, "R6", "read data", got_d, d);
            check(rd_data == d, "R6", "read data held", rd_data, d);
            check(got_e == ta, "R7", "turnaround error flag", got_e, ta);
        end else begin
            check(mon[17:0] == ef[17:0], "R5", "write turnaround+data", mon[17:0], ef[17:0]);
            check(got_e == 1'b0, "R7", "no error on write", got_e, 0);
        end
    endtask

    initial begin
        #(CLK_NS * 180000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev_rd;
        void'($urandom(32'h5eed_0a11));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mdio_oe && !mdc && !done && !rd_err, "R1", "reset state",
              {mdio_oe, mdc, done, rd_err}, 0);

        run_txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 8'd0, 1'b0, 1'b0);
        run_txn(1'b0, 5'h00, 5'h00, 16'h0000, 8'd4, 1'b0, 1'b0);
        run_txn(1'b0, 5'h15, 5'h0A, 16'hA5C3, 8'd9, 1'b0, 1'b0);
        run_txn(1'b1, 5'h01, 5'h10, 16'h8001, 8'd3, 1'b0, 1'b0);
        run_txn(1'b1, 5'h1E, 5'h01, 16'hFFFF, 8'd5, 1'b0, 1'b0);
        run_txn(1'b1, 5'h0C, 5'h13, 16'h0000, 8'd6, 1'b0, 1'b0);
        run_txn(1'b1, 5'h07, 5'h02, 16'h5AA5, 8'd4, 1'b1, 1'b0);
        run_txn(1'b0, 5'h0B, 5'h1C, 16'h1234, 8'd7, 1'b0, 1'b1);
        run_txn(1'b1, 5'h12, 5'h05, 16'hC0DE, 8'd5, 1'b0, 1'b1);
        run_txn(1'b0, 5'h03, 5'h04, 16'h0F0F, 8'd255, 1'b0, 1'b0);
        prev_rd = rd_data;
        check(prev_rd == 16'hC0DE, "R6", "rd_data kept across write", prev_rd, 16'hC0DE);

        for (int i = 0; i < 14; i++) begin
            logic rr;
            rr = 1'($urandom);
            run_txn(rr, 5'($urandom), 5'($urandom), 16'($urandom),
                    8'($urandom % 13), rr & (($urandom % 4) == 0), 1'b0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule